// File: doc/BRIEF.md
# Two-Stage UART Baud Tick Generator

This block turns a reference clock into the two clock-enable strobes a UART needs. The first is a sample tick at the oversampling rate. The second is a bit tick at the baud rate. It works in two cascaded stages.

A source selector passes either every reference cycle or every eighth one. A 16-bit divisor counter then thins that source into sample ticks. A second counter groups a programmable number of sample ticks into one bit period. The baud rate is the source rate divided by the divisor and by the samples-per-bit count.

Both settings are loaded through single-cycle write strobes. Any accepted write restarts every counter, so a period never mixes old and new settings. A divisor of zero parks the generator. A samples-per-bit setting below the legal minimum is refused, and the previous setting stays in force.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is 651 (0x28B) and the samples-per-bit field is 15, so there are 16 samples per bit. With the prescaler off, the first sample tick comes in cycle 650 and the first bit tick in cycle 10415. Cycle 0 is the first cycle after the last reset edge.
- R2: While the divisor is 0, neither sample_tick nor bit_tick is ever asserted.
- R3: With divisor D (1 to 65535) and a source factor P, sample_tick is high in exactly one cycle out of every D*P. P is 1 when pre8_sel is 0 and 8 when pre8_sel is 1.
- R4: With pre8_sel held at 1, sample_tick is never high in two consecutive cycles.
- R5: With field value N (4 to 255), bit_tick is high on every (N+1)-th sample tick and only in cycles where sample_tick is high. A bit period therefore lasts (N+1)*D*P cycles.
- R6: A spb_wr write of a value from 0 to 3 is ignored. The previous field value is kept and the counters are not restarted.
- R7: An accepted write on div_wr or spb_wr restarts all counters. The first sample tick then comes D*P-1 cycles after the write cycle, and the first bit tick comes (N+1)*D*P-1 cycles after it.
- R8: The extreme settings work: field value 255 (256 samples per bit) and divisor 65535.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_wr | input | 1 | Load strobe for the first-stage divisor |
| div_val | input | 16 | Divisor value (0 = generator off) |
| spb_wr | input | 1 | Load strobe for the samples-per-bit field |
| spb_val | input | 8 | Samples per bit minus one (legal range 4 to 255) |
| pre8_sel | input | 1 | 0 = reference clock as source, 1 = reference clock divided by 8 |
| sample_tick | output | 1 | One-cycle enable at the oversampling rate |
| bit_tick | output | 1 | One-cycle enable at the baud rate |

## Verification
The bench sweeps divisors 1 to 6 against field values 4 to 7, with the prescaler both off and on. In each case it measures when the first sample tick and first bit tick arrive after the restart, how many cycles separate consecutive bit ticks, and how many sample ticks fall in two bit periods. The arrival times separate a missing or extra restart from an off-by-one in either terminal count. The gap and the tick count separate a wrong samples-per-bit factor from a wrong source factor.

Further runs cover the reset defaults, the extremes 255 and 65535, a zero divisor with each source, and an illegal field write made in the middle of a period. That last run shows whether the write changed the setting or disturbed the phase.

// File: rtl/baud_gen_pkg.sv
// Package: shared widths, reset values and limits for the baud tick generator.
package baud_gen_pkg;
    localparam int DIV_W     = 16;        // first-stage divisor width
    localparam int SPB_W     = 8;         // samples-per-bit field width
    localparam int PRE_RATIO = 8;         // slow source divides by this
    localparam logic [DIV_W-1:0] DIV_RESET = 16'h028B;
    localparam logic [SPB_W-1:0] SPB_RESET = 8'h0F;
    localparam logic [SPB_W-1:0] SPB_MIN   = 8'd4;
endpackage

// File: rtl/bgen_cfg_regs.sv
// Module: bgen_cfg_regs
// Holds the divisor and samples-per-bit settings. It refuses field values
// below MIN, and it raises a one-cycle restart for every accepted write.
// Assumes: writes are single-cycle strobes in the clk domain.
module bgen_cfg_regs #(
    parameter int DIV_W = 16,
    parameter int SPB_W = 8,
    parameter logic [DIV_W-1:0] DIV_INIT = '0,
    parameter logic [SPB_W-1:0] SPB_INIT = '0,
    parameter logic [SPB_W-1:0] SPB_MIN  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic             spb_wr,
    input  logic [SPB_W-1:0] spb_val,
    output logic [DIV_W-1:0] div_q,
    output logic [SPB_W-1:0] spb_q,
    output logic             restart
);
    logic spb_ok;

    // Purpose: decide whether a field write is legal.
    always_comb spb_ok = spb_wr && (spb_val >= SPB_MIN);

    // Purpose: an accepted write of either setting restarts the counters.
    always_comb restart = div_wr || spb_ok;

    // Purpose: setting storage with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_INIT;
            spb_q <= SPB_INIT;
        end else begin
            if (div_wr) div_q <= div_val;
            if (spb_ok) spb_q <= spb_val;
        end
    end
endmodule

// File: rtl/bgen_prescale.sv
// Module: bgen_prescale
// Makes the source enable. It is high every cycle when sel is 0, and high
// once every RATIO cycles when sel is 1.
// Assumes: RATIO >= 2; restart realigns the phase.
module bgen_prescale #(
    parameter int RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sel,
    output logic src_en
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt;

    // Purpose: free-running phase counter that wraps at RATIO-1.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // Purpose: pass every cycle, or only the terminal phase.
    always_comb src_en = sel ? (cnt == LAST) : 1'b1;
endmodule

// File: rtl/bgen_count_div.sv
// Module: bgen_count_div
// Counts enable pulses from 0 up to LAST and pulses on the enable that
// reaches LAST. Used for both stages.
// Assumes: LAST is stable between restarts; active=0 freezes the counter.
module bgen_count_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         en,
    input  logic         active,
    input  logic [W-1:0] last,
    output logic         pulse
);
    logic [W-1:0] cnt;

    // Purpose: count enables and wrap at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  cnt <= '0;
        else if (en && active)  cnt <= (cnt >= last) ? '0 : cnt + 1'b1;
    end

    // Purpose: strobe on the enable that completes the count.
    always_comb pulse = en && active && (cnt >= last);
endmodule

// File: rtl/baud_tick_gen.sv
// Module: baud_tick_gen (top)
// Chain: source select -> divisor stage (sample tick) -> samples-per-bit
// stage (bit tick). A zero divisor holds both ticks low.
// Assumes: clk is the reference clock; all inputs are synchronous to it.
module baud_tick_gen
    import baud_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic             spb_wr,
    input  logic [SPB_W-1:0] spb_val,
    input  logic             pre8_sel,
    output logic             sample_tick,
    output logic             bit_tick
);
    logic [DIV_W-1:0] div_q;
    logic [SPB_W-1:0] spb_q;
    logic             restart;
    logic             src_en;
    logic             div_on;
    logic [DIV_W-1:0] div_last;

    bgen_cfg_regs #(
        .DIV_W(DIV_W), .SPB_W(SPB_W),
        .DIV_INIT(DIV_RESET), .SPB_INIT(SPB_RESET), .SPB_MIN(SPB_MIN)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .div_wr(div_wr), .div_val(div_val),
        .spb_wr(spb_wr), .spb_val(spb_val),
        .div_q(div_q), .spb_q(spb_q), .restart(restart)
    );

    bgen_prescale #(.RATIO(PRE_RATIO)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .sel(pre8_sel), .src_en(src_en)
    );

    // Purpose: a zero divisor disables; otherwise wrap at divisor-1.
    always_comb begin
        div_on   = (div_q != '0);
        div_last = div_q - 1'b1;
    end

    bgen_count_div #(.W(DIV_W)) u_sample (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .en(src_en), .active(div_on), .last(div_last),
        .pulse(sample_tick)
    );

    bgen_count_div #(.W(SPB_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .en(sample_tick), .active(1'b1), .last(spb_q),
        .pulse(bit_tick)
    );
endmodule

// File: rtl/bgen_checker.sv
// Module: bgen_checker
// Temporal checks on the baud tick generator, bound to the top module.
module bgen_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        spb_wr,
    input logic [7:0]  spb_val,
    input logic        pre8_sel,
    input logic [15:0] div_q,
    input logic [7:0]  spb_q,
    input logic        sample_tick,
    input logic        bit_tick
);
    logic was_reset = 1'b0;

    // Purpose: remember that the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        was_reset <= !rst_n;
        if (was_reset) begin
            a_r1_reset_defaults: assert (div_q == 16'h028B && spb_q == 8'h0F)
                else $error("R1 reset defaults wrong");
        end
    end

    a_r2_zero_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == 16'd0) |-> (!sample_tick && !bit_tick));

    a_r4_pre8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && pre8_sel) |=> (!pre8_sel || !sample_tick));

    a_r5_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

    a_r6_illegal_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (spb_wr && spb_val < 8'd4) |=> $stable(spb_q));

    a_r6_field_legal: assert property (@(posedge clk) disable iff (!rst_n)
        spb_q >= 8'd4);
endmodule

bind baud_tick_gen bgen_checker u_bgen_checker (
    .clk(clk), .rst_n(rst_n), .spb_wr(spb_wr), .spb_val(spb_val),
    .pre8_sel(pre8_sel), .div_q(div_q), .spb_q(spb_q),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
);

// File: tb/baud_tick_gen_test.sv
// Bench: sweeps small settings and computes tick timing arithmetically.
module baud_tick_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_wr = 1'b0;
    logic [15:0] div_val = '0;
    logic        spb_wr = 1'b0;
    logic [7:0]  spb_val = '0;
    logic        pre8_sel = 1'b0;
    logic        sample_tick, bit_tick;

    int errors = 0;
    int checks = 0;
    int m_first_s, m_count_s, m_first_b, m_second_b, m_count_b;

    always #10 clk = ~clk;   // 50 MHz

    baud_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_val(div_val),
        .spb_wr(spb_wr), .spb_val(spb_val), .pre8_sel(pre8_sel),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Leaves the bench at the negedge that is cycle 0 after the write.
    task automatic write_div(input int v);
        @(negedge clk); div_wr = 1'b1; div_val = 16'(v);
        @(negedge clk); div_wr = 1'b0;
    endtask

    task automatic write_spb(input int v);
        @(negedge clk); spb_wr = 1'b1; spb_val = 8'(v);
        @(negedge clk); spb_wr = 1'b0;
    endtask

    // Samples n cycles from cycle 0. At poke_at it drives a field write.
    task automatic measure(input int n, input int poke_at, input int poke_val);
        m_first_s = -1; m_count_s = 0; m_first_b = -1; m_second_b = -1; m_count_b = 0;
        for (int i = 0; i < n; i++) begin
            if (sample_tick) begin
                if (m_first_s < 0) m_first_s = i;
                m_count_s++;
            end
            if (bit_tick) begin
                if (m_first_b < 0) m_first_b = i;
                else if (m_second_b < 0) m_second_b = i;
                m_count_b++;
            end
            if (i == poke_at) begin spb_wr = 1'b1; spb_val = 8'(poke_val); end
            @(negedge clk);
            spb_wr = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;                       // this negedge is cycle 0
        measure(10416, -1, 0);
        check("R1 first sample", m_first_s, 650);
        check("R1 first bit", m_first_b, 10415);
        check("R1 sample count", m_count_s, 16);

        // R3 R5 R7 sweep over divisor, field value and source.
        for (int p = 0; p < 2; p++) begin
            for (int d = 1; d <= 6; d++) begin
                for (int s = 4; s <= 7; s++) begin
                    int pf, b;
                    pf = (p == 1) ? 8 : 1;
                    b  = (s + 1) * d * pf;
                    pre8_sel = (p == 1);
                    write_spb(s);
                    write_div(d);
                    measure(2 * b, -1, 0);
                    check("R7 first sample", m_first_s, d * pf - 1);
                    check("R3 sample count", m_count_s, 2 * (s + 1));
                    check("R7 first bit", m_first_b, b - 1);
                    check("R5 bit gap", m_second_b - m_first_b, b);
                end
            end
        end

        // R2: zero divisor with each source.
        for (int p = 0; p < 2; p++) begin
            pre8_sel = (p == 1);
            write_div(0);
            measure(300, -1, 0);
            check("R2 no sample", m_count_s, 0);
            check("R2 no bit", m_count_b, 0);
        end

        // R6: an illegal write mid-period keeps the setting and the phase.
        pre8_sel = 1'b0;
        write_spb(5);
        write_div(3);
        measure(36, 4, 2);
        check("R6 first bit kept", m_first_b, 17);
        check("R6 bit gap kept", m_second_b - m_first_b, 18);
        write_spb(0);
        write_div(2);
        measure(24, -1, 0);
        check("R6 after zero write", m_first_b, 11);

        // R8: extremes.
        write_spb(255);
        write_div(1);
        measure(512, -1, 0);
        check("R8 spb255 first bit", m_first_b, 255);
        check("R8 spb255 gap", m_second_b - m_first_b, 256);
        check("R4 R8 continuous samples", m_count_s, 512);
        write_div(65535);
        measure(65535, -1, 0);
        check("R8 div65535 first sample", m_first_s, 65534);
        check("R8 div65535 count", m_count_s, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule